// File: doc/BRIEF.md
# Transmit Pad Removal and Realignment Stage

This stage sits on the transmit side of a 64-bit packet path, between an internal stream and the MAC input. Each frame arriving on the internal stream begins with six bytes of leading padding. The stage drops those six bytes and shifts the remaining bytes down across word boundaries. It then presents the frame in the MAC transmit format. That format carries a start-of-frame flag and a last-word byte count in a 4-bit sideband.

Both sides use a valid/ready handshake, and the data path from input to output is combinational. Each output word is built from the two upper bytes of the previous input word, held in a register, together with the six lower bytes of the current input word.

A frame can end with seven or eight bytes in its final input word. Those bytes do not fit into the shifted word, so the stage emits one extra tail word. While that tail word waits to be accepted, the input is stalled. A frame whose final word holds six or fewer bytes folds its tail into the shifted word, and no extra beat is produced.

Byte k of a word sits on bits 8k+7:8k. Byte 0 is the earliest in the frame.

Top module: `tx_pad_strip`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `m_valid` is 0 and `s_ready` is 1.
- R2: The six leading bytes of every input frame never appear on the output. The output payload is exactly input bytes 6 onward, in order.
- R3: Output word n carries input bytes 6 and 7 of input word n in output byte lanes 0 and 1. It carries bytes 0 to 5 of input word n+1 in output byte lanes 2 to 7.
- R4: `m_user[3]` is 1 on the first output beat of each frame and 0 on every other beat. It is 0 whenever `m_valid` is 0.
- R5: `m_user[2:0]` is 0 on beats that are not last. On a last beat it holds the count of valid bytes, with 0 meaning 8. The input count `s_occ` uses the same encoding and is only meaningful with `s_last`.
- R6: If the final input word of a multi-word frame has `s_occ` from 1 to 6, the last output beat is issued in the same cycle that this word is accepted, and it holds 2 + `s_occ` bytes.
- R7: If the final input word has `s_occ` of 7 or 0, one extra last output word follows, holding 1 or 2 bytes respectively. `s_ready` stays 0 until that word is accepted.
- R8: In the middle of a frame, `s_ready` equals `m_ready`. While a tail word is not accepted, it is held stable on the output.
- R9: A single-word input frame with 7 or 8 valid bytes produces one single-beat output frame of 1 or 2 bytes, flagged as both first and last. Frames must carry at least one payload byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | 64 | Padded input data, byte 0 in bits 7:0 |
| s_occ | input | 3 | Valid bytes in final input word, 0 means 8 |
| s_last | input | 1 | Final word of input frame |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high with s_valid |
| m_data | output | 64 | Realigned output data |
| m_user | output | 4 | Bit 3 start of frame, bits 2:0 last-word byte count |
| m_last | output | 1 | Final word of output frame |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts output word |

## Verification
The stage has no parameters, so the bench builds it with its fixed 64-bit word. Instead, it sweeps every frame length from 7 to 40 bytes. This puts each of the eight final-word byte counts, both the merged and the tail endings, and single-word frames within reach. The sweep runs under three flow patterns: a free-flowing downstream, alternating ready with steady input, and pseudo-random gaps on both sides. Together these expose the tail stall, the ready pass-through and hold stability under backpressure.

// File: rtl/tx_pad_strip.sv
module tx_pad_strip (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] s_data,
  input  logic [2:0]  s_occ,
  input  logic        s_last,
  input  logic        s_valid,
  output logic        s_ready,
  output logic [63:0] m_data,
  output logic [3:0]  m_user,
  output logic        m_last,
  output logic        m_valid,
  input  logic        m_ready
);

  logic [15:0] carry_q;
  logic [2:0]  tail_cnt_q;
  logic        mid_q;
  logic        tail_q;
  logic        first_q;
  logic [2:0]  cnt_out;

  wire long_end = (s_occ == 3'd0) || (s_occ == 3'd7);
  wire s_fire   = s_valid && s_ready;
  wire m_fire   = m_valid && m_ready;

  assign s_ready = tail_q ? 1'b0 : (mid_q ? m_ready : 1'b1);
  assign m_valid = tail_q || (mid_q && s_valid);
  assign m_data  = tail_q ? {48'd0, carry_q} : {s_data[47:0], carry_q};
  assign m_last  = tail_q || (mid_q && s_last && !long_end);
  assign cnt_out = tail_q ? tail_cnt_q :
                   (s_last && !long_end) ? s_occ + 3'd2 : 3'd0;
  assign m_user  = {first_q && m_valid, cnt_out};

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q    <= '0;
      tail_cnt_q <= '0;
      mid_q      <= 1'b0;
      tail_q     <= 1'b0;
      first_q    <= 1'b1;
    end else begin
      if (m_fire) first_q <= m_last;
      if (tail_q && m_ready) tail_q <= 1'b0;
      if (s_fire) begin
        carry_q <= s_data[63:48];
        if (s_last) begin
          mid_q      <= 1'b0;
          tail_q     <= long_end;
          tail_cnt_q <= s_occ + 3'd2;
        end else begin
          mid_q <= 1'b1;
        end
      end
    end
  end

  AST_SOF_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (m_fire && m_last) |=> (!m_valid || m_user[3])); // R4

  AST_NO_SOF_MID: assert property (@(posedge clk) disable iff (rst)
    (m_fire && !m_last) |=> !m_user[3]); // R4

  AST_SOF_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !m_valid |-> !m_user[3]); // R4

  AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (s_fire && s_last && long_end) |=> (m_valid && m_last && !s_ready)); // R7

  AST_MERGED_END: assert property (@(posedge clk) disable iff (rst)
    (s_fire && s_last && !long_end && mid_q) |-> (m_valid && m_last && m_user[2:0] == s_occ + 3'd2)); // R6

  AST_TAIL_HELD: assert property (@(posedge clk) disable iff (rst)
    (tail_q && !m_ready) |=> (m_valid && m_last && $stable(m_data) && $stable(m_user))); // R8

endmodule

// File: tb/tx_pad_strip_test.sv
module tx_pad_strip_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] s_data;
  logic [2:0]  s_occ;
  logic        s_last;
  logic        s_valid;
  logic        s_ready;
  logic [63:0] m_data;
  logic [3:0]  m_user;
  logic        m_last;
  logic        m_valid;
  logic        m_ready;

  always #10 clk = ~clk;

  tx_pad_strip uut (
    .clk(clk), .rst(rst),
    .s_data(s_data), .s_occ(s_occ), .s_last(s_last), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_user(m_user), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int fr, input int idx);
    return 8'((fr * 7 + idx * 13 + 1) & 255);
  endfunction

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int fr;
    logic [7:0] lfsr;
    rst = 1'b1; s_data = '0; s_occ = '0; s_last = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    fr = 0;
    lfsr = 8'h5a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R1", "reset state", {m_valid, s_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R1", "after release", {m_valid, s_ready}, 2'b01);

    for (int p = 0; p < 3; p++) begin
      for (int L = 7; L <= 40; L++) begin
        int bi, ob, P, cyc;
        bit sv, stall;
        logic [63:0] pd;
        logic [3:0]  pu;
        bi = 0; ob = 0; P = L - 6; cyc = 0; sv = 0; stall = 0; pd = '0; pu = '0;
        while (bi < L || ob < P) begin
          @(negedge clk);
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          if (!sv && bi < L) sv = (p == 2) ? lfsr[0] : 1'b1;
          if (bi >= L) sv = 0;
          s_valid = sv;
          for (int k = 0; k < 8; k++)
            s_data[8*k +: 8] = (bi + k < L) ? fbyte(fr, bi + k) : 8'hEE;
          s_last = (L - bi) <= 8;
          s_occ  = s_last ? 3'(L - bi) : 3'd0;
          m_ready = (p == 0) ? 1'b1 : (p == 1) ? cyc[0] : lfsr[2];
          #1;
          if (stall)
            chk(m_valid && m_data == pd && m_user == pu, "R8", "held word", m_data, pd);
          if (bi >= L && ob < P)
            chk(!s_ready, "R7", "stall during tail", s_ready, 0);
          if (bi > 0 && bi < L)
            chk(s_ready == m_ready, "R8", "ready pass", s_ready, m_ready);
          if (!m_valid)
            chk(!m_user[3], "R4", "sof idle", m_user[3], 0);
          if (m_valid && m_ready) begin
            int rem, nb;
            bit exl;
            logic [63:0] mask, expw;
            rem = P - ob;
            exl = rem <= 8;
            nb  = exl ? rem : 8;
            mask = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
            expw = '0;
            for (int k = 0; k < nb; k++) expw[8*k +: 8] = fbyte(fr, 6 + ob + k);
            chk((m_data & mask) == expw, "R2 R3", "payload", m_data & mask, expw);
            chk(m_last == exl, (L <= 8) ? "R9" : (((L % 8) == 7 || (L % 8) == 0) ? "R7" : "R6"),
                "last flag", m_last, exl);
            chk(m_user[2:0] == (exl ? 3'(rem) : 3'd0), "R5", "count", m_user[2:0], exl ? 3'(rem) : 3'd0);
            chk(m_user[3] == (ob == 0), "R4", "sof", m_user[3], ob == 0);
            ob += 8;
          end
          stall = m_valid && !m_ready;
          pd = m_data;
          pu = m_user;
          if (s_valid && s_ready) begin
            bi += 8;
            sv = 0;
          end
          cyc++;
          if (cyc > 300) begin
            chk(1'b0, "R8", "frame progress", cyc, 300);
            break;
          end
        end
        fr++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    m_ready = 1'b1;
    #1;
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R1", "idle after sweep", {m_valid, s_ready}, 2'b01);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule